// File: doc/BRIEF.md
# Accumulator ALU with Half-Carry Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. Each cycle it takes an operation code, an accumulator (or 16-bit) operand, a second operand and the incoming four-bit flag set. One clock edge later it presents the result and the updated flags on registered outputs. Operand fetch, memory access and instruction decode live elsewhere. The block only computes values and flags.

Each operation carries its own flag rule. Some flags are computed, some are forced to 0 or 1, and the rest pass through from the incoming set. The half-carry flag is taken from the nibble boundary for byte operations. For the 16-bit register-pair add it comes from bit 11. For the stack-pointer signed add, both H and C come from the low byte.

Top module: `accalu_core`

## Requirements
- R1: While the synchronous active-high reset is held, the result reads 0 and the flags read 0. Otherwise, the outputs reflect the inputs of the previous clock edge (one-cycle latency).
- R2: Opcodes 0 (add) and 1 (add with carry) place the byte sum in result[7:0]. For opcode 1, the incoming C is an extra addend. Z is set when the byte result is 0, and N is 0. H is the carry out of bit 3 and C is the carry out of bit 7.
- R3: Opcodes 2 (subtract) and 3 (subtract with borrow) place the byte difference in result[7:0]. For opcode 3, the incoming C is also subtracted. N is 1 and Z is set when the result is 0. H is the borrow from bit 4. C is set when the subtrahend (plus borrow) exceeds the accumulator.
- R4: Opcode 4 (compare) sets the flags exactly as opcode 2 would. Its result is the accumulator byte, unchanged.
- R5: Opcode 5 (AND) gives the bitwise AND. Z is set when the result is 0, N is 0, H is forced to 1 and C is forced to 0.
- R6: Opcodes 6 (OR) and 7 (XOR) give the bitwise result. Z is set when the result is 0, and N, H and C are 0.
- R7: Opcode 8 (increment) adds 1 to the accumulator byte. It clears N and sets H on a carry out of bit 3. Opcode 9 (decrement) subtracts 1. It sets N and sets H on a borrow from bit 4. Both set Z when the result is 0, and both keep the incoming C.
- R8: Opcode 10 (complement) inverts all eight accumulator bits and forces N and H to 1. It keeps Z and C.
- R9: Opcode 11 forces C to 1, and opcode 12 inverts C. Both clear N and H, keep Z, and pass the 16-bit accumulator operand to the result.
- R10: Opcode 13 (16-bit pair add) outputs the 16-bit sum of both operands. It keeps Z and clears N. H is the carry out of bit 11 and C is the carry out of bit 15.
- R11: Opcode 14 (stack add) adds the sign-extended low byte of the second operand to the 16-bit operand. Z and N are forced to 0. H and C are the carries out of bits 3 and 7 of the unsigned low-byte sum.
- R12: Flags are packed {Z,N,H,C} in bits [3:0]. Byte operations zero the result's upper byte. Opcode 15 passes the 16-bit accumulator operand through and keeps all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 16 | Accumulator (low byte) or 16-bit operand |
| opb_i | input | 16 | Second operand (low byte for byte and stack operations) |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| result_o | output | 16 | Registered result |
| flags_o | output | 4 | Registered updated flags {Z,N,H,C} |

## Verification
The bench builds the block with its default byte width of 8. This keeps the operand space at 65,536 pairs, so add-with-carry and subtract-with-borrow are each swept over every pair. The carry-in alternates with operand parity, so both carry values occur in every row. The plain add, subtract, compare and logic operations use strided grids. Increment and decrement see every accumulator value with both carry inputs. The 16-bit adds are driven through corner operands at the bit-11, bit-15 and sign-extension boundaries.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_CP    = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_INC   = 4'd8,
    OP_DEC   = 4'd9,
    OP_CPL   = 4'd10,
    OP_SCF   = 4'd11,
    OP_CCF   = 4'd12,
    OP_ADDW  = 4'd13,
    OP_ADDSP = 4'd14,
    OP_NOP   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/accalu_arith8.sv
module accalu_arith8
  import accalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           h,
  output logic           c
);
  localparam int NW = DW / 2;

  logic          sub;
  logic          cy;
  logic [DW-1:0] bx;
  logic [NW:0]   lo;
  logic [DW:0]   full;

  always_comb begin
    sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) || (op == OP_DEC);
    cy  = ((op == OP_ADC) || (op == OP_SBC)) ? cin : 1'b0;
    bx  = ((op == OP_INC) || (op == OP_DEC)) ? {{(DW-1){1'b0}}, 1'b1} : b;
    if (sub) begin
      // top bit of each difference is the borrow out of that width
      lo   = {1'b0, a[NW-1:0]} - {1'b0, bx[NW-1:0]} - {{NW{1'b0}}, cy};
      full = {1'b0, a} - {1'b0, bx} - {{DW{1'b0}}, cy};
    end else begin
      lo   = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cy};
      full = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cy};
    end
    res = full[DW-1:0];
    h   = lo[NW];
    c   = full[DW];
  end

endmodule

// File: rtl/accalu_logic8.sv
module accalu_logic8
  import accalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      default: res = a;
    endcase
  end

endmodule

// File: rtl/accalu_wide.sv
module accalu_wide
  import accalu_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  alu_op_e       op,
  input  logic [WW-1:0] a,
  input  logic [WW-1:0] b,
  output logic [WW-1:0] res,
  output logic          h,
  output logic          c
);
  localparam int NW = DW / 2;
  localparam int LW = WW - NW;   // pair-add half carry taken above this width

  logic [WW-1:0] sext;
  logic [LW:0]   lo_pair;
  logic [WW:0]   full_pair;
  logic [NW:0]   lo_sp;
  logic [DW:0]   byte_sp;

  always_comb begin
    sext      = {{DW{b[DW-1]}}, b[DW-1:0]};
    lo_pair   = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
    full_pair = {1'b0, a} + {1'b0, b};
    lo_sp     = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]};
    byte_sp   = {1'b0, a[DW-1:0]} + {1'b0, b[DW-1:0]};
    if (op == OP_ADDSP) begin
      res = a + sext;
      h   = lo_sp[NW];
      c   = byte_sp[DW];
    end else begin
      res = full_pair[WW-1:0];
      h   = lo_pair[LW];
      c   = full_pair[WW];
    end
  end

endmodule

// File: rtl/accalu_core.sv
module accalu_core
  import accalu_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic [WW-1:0] acc_i,
  input  logic [WW-1:0] opb_i,
  input  logic [3:0]    flags_i,
  output logic [WW-1:0] result_o,
  output logic [3:0]    flags_o
);
  localparam logic [DW-1:0] ZHI = '0;

  alu_op_e    op;
  alu_flags_t fi;
  alu_flags_t nf;
  logic [WW-1:0] nr;

  logic [DW-1:0] ar, lr;
  logic          ah, ac;
  logic [WW-1:0] wr;
  logic          wh, wc;

  assign op = alu_op_e'(op_i);
  assign fi = alu_flags_t'(flags_i);

  accalu_arith8 #(.DW(DW)) u_arith (
    .op(op), .a(acc_i[DW-1:0]), .b(opb_i[DW-1:0]), .cin(fi.c),
    .res(ar), .h(ah), .c(ac)
  );

  accalu_logic8 #(.DW(DW)) u_logic (
    .op(op), .a(acc_i[DW-1:0]), .b(opb_i[DW-1:0]), .res(lr)
  );

  accalu_wide #(.DW(DW)) u_wide (
    .op(op), .a(acc_i), .b(opb_i), .res(wr), .h(wh), .c(wc)
  );

  always_comb begin
    nf = fi;
    nr = acc_i;
    unique case (op)
      OP_ADD, OP_ADC: begin
        nr = {ZHI, ar};
        nf = '{z: ~|ar, n: 1'b0, h: ah, c: ac};
      end
      OP_SUB, OP_SBC: begin
        nr = {ZHI, ar};
        nf = '{z: ~|ar, n: 1'b1, h: ah, c: ac};
      end
      OP_CP: begin
        nr = {ZHI, acc_i[DW-1:0]};
        nf = '{z: ~|ar, n: 1'b1, h: ah, c: ac};
      end
      OP_AND: begin
        nr = {ZHI, lr};
        nf = '{z: ~|lr, n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_OR, OP_XOR: begin
        nr = {ZHI, lr};
        nf = '{z: ~|lr, n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_INC: begin
        nr = {ZHI, ar};
        nf = '{z: ~|ar, n: 1'b0, h: ah, c: fi.c};
      end
      OP_DEC: begin
        nr = {ZHI, ar};
        nf = '{z: ~|ar, n: 1'b1, h: ah, c: fi.c};
      end
      OP_CPL: begin
        nr = {ZHI, lr};
        nf = '{z: fi.z, n: 1'b1, h: 1'b1, c: fi.c};
      end
      OP_SCF: nf = '{z: fi.z, n: 1'b0, h: 1'b0, c: 1'b1};
      OP_CCF: nf = '{z: fi.z, n: 1'b0, h: 1'b0, c: ~fi.c};
      OP_ADDW: begin
        nr = wr;
        nf = '{z: fi.z, n: 1'b0, h: wh, c: wc};
      end
      OP_ADDSP: begin
        nr = wr;
        nf = '{z: 1'b0, n: 1'b0, h: wh, c: wc};
      end
      default: begin
        nr = acc_i;
        nf = fi;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= nr;
      flags_o  <= nf;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result_o == '0 && flags_o == 4'd0));

  // R4
  cp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_CP |=> result_o == {ZHI, $past(acc_i[DW-1:0])});

  // R5
  and_forced_flags_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_AND |=> (flags_o[2:0] == 3'b010));

  // R7
  incdec_keep_c_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[0] == $past(flags_i[0]));

  // R9
  scf_forced_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_SCF |=> (flags_o[2:0] == 3'b001 && flags_o[3] == $past(flags_i[3])));

  // R10
  pair_add_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_ADDW |=> (flags_o[3] == $past(flags_i[3]) && !flags_o[2]));

  // R11
  stack_add_zn_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_ADDSP |=> flags_o[3:2] == 2'b00);

  // R12
  nop_pass_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_NOP |=> (flags_o == $past(flags_i) && result_o == $past(acc_i)));

endmodule

// File: tb/accalu_core_test.sv
module accalu_core_test;
  localparam int OADD = 0, OADC = 1, OSUB = 2, OSBC = 3, OCP = 4, OAND = 5,
                 OOR = 6, OXOR = 7, OINC = 8, ODEC = 9, OCPL = 10, OSCF = 11,
                 OCCF = 12, OADDW = 13, OADDSP = 14, ONOP = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [15:0] acc_i = '0;
  logic [15:0] opb_i = '0;
  logic [3:0]  flags_i = '0;
  logic [15:0] result_o;
  logic [3:0]  flags_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  accalu_core uut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opb_i(opb_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
  );

  // Reference model: returns {result[15:0], Z, N, H, C}
  function automatic logic [19:0] model(int op, int a, int b, logic [3:0] f);
    int al, bl, ci, s, r, k, sb, se;
    logic z, n, h, c;
    al = a & 255; bl = b & 255; ci = int'(f[0]);
    z = f[3]; n = f[2]; h = f[1]; c = f[0]; r = a;
    case (op)
      OADD, OADC: begin
        k = (op == OADC) ? ci : 0;
        s = al + bl + k; r = s & 255;
        z = (r == 0); n = 0; h = ((al & 15) + (bl & 15) + k) > 15; c = s > 255;
      end
      OSUB, OSBC, OCP: begin
        k = (op == OSBC) ? ci : 0;
        s = (al - bl - k) & 255;
        r = (op == OCP) ? al : s;
        z = (s == 0); n = 1; h = (al & 15) < ((bl & 15) + k); c = al < (bl + k);
      end
      OAND: begin r = al & bl; z = (r == 0); n = 0; h = 1; c = 0; end
      OOR:  begin r = al | bl; z = (r == 0); n = 0; h = 0; c = 0; end
      OXOR: begin r = al ^ bl; z = (r == 0); n = 0; h = 0; c = 0; end
      OINC: begin r = (al + 1) & 255; z = (r == 0); n = 0; h = (al & 15) == 15; end
      ODEC: begin r = (al - 1) & 255; z = (r == 0); n = 1; h = (al & 15) == 0; end
      OCPL: begin r = (~al) & 255; n = 1; h = 1; end
      OSCF: begin n = 0; h = 0; c = 1; end
      OCCF: begin n = 0; h = 0; c = ~f[0]; end
      OADDW: begin
        s = a + b; r = s & 65535;
        n = 0; h = ((a & 4095) + (b & 4095)) > 4095; c = s > 65535;
      end
      OADDSP: begin
        sb = bl; se = (sb >= 128) ? sb - 256 : sb;
        r = (a + se) & 65535;
        z = 0; n = 0; h = ((a & 15) + (sb & 15)) > 15; c = (al + sb) > 255;
      end
      default: r = a;
    endcase
    model = {r[15:0], z, n, h, c};
  endfunction

  // Drive one vector at a falling edge, sample at the next falling edge.
  task automatic apply(int op, int a, int b, logic [3:0] f, string req);
    logic [19:0] exp;
    exp = model(op, a & 65535, b & 65535, f);
    op_i = op[3:0]; acc_i = a[15:0]; opb_i = b[15:0]; flags_i = f;
    @(negedge clk);
    n_run++;
    if (result_o !== exp[19:4] || flags_o !== exp[3:0]) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h f=%b: actual res=%h flags=%b expected res=%h flags=%b",
               req, op, a[15:0], b[15:0], f, result_o, flags_o, exp[19:4], exp[3:0]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op_i = 4'(OADD); acc_i = 16'h00ff; opb_i = 16'h0001; flags_i = 4'hf;
    repeat (3) @(negedge clk);
    n_run++;
    if (result_o !== 16'h0 || flags_o !== 4'h0) begin
      n_fail++;
      $display("FAIL R1 reset: actual res=%h flags=%b expected res=0000 flags=0000", result_o, flags_o);
    end
    rst = 1'b0;
  endtask

  // R2 exhaustive add-with-carry, carry-in alternates with parity
  task automatic t_adc_sweep();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(OADC, a, b, {2'b10, 1'b0, 1'((a + b) & 1)}, "R2");
  endtask

  // R3 exhaustive subtract-with-borrow
  task automatic t_sbc_sweep();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(OSBC, a, b, {2'b01, 1'b1, 1'((a ^ b ^ 1) & 1)}, "R3");
  endtask

  // R2, R3, R4 plain forms on a strided grid (C in set to show it is unused)
  task automatic t_plain_arith();
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 5) begin
        apply(OADD, a, b, 4'b0001, "R2");
        apply(OSUB, a, b, 4'b1001, "R3");
        apply(OCP,  a, b, 4'b0111, "R4");
      end
    apply(OCP, 8'h3c, 8'h3c, 4'b0000, "R4");
    apply(OCP, 8'h10, 8'h01, 4'b0000, "R4");
  endtask

  // R5, R6, R8 logic and complement
  task automatic t_logic();
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 7) begin
        apply(OAND, a, b, 4'b0101, "R5");
        apply(OOR,  a, b, 4'b1111, "R6");
        apply(OXOR, a, b, 4'b0011, "R6");
        apply(OCPL, a, b, {1'(a & 1), 2'b00, 1'(b & 1)}, "R8");
      end
    apply(OXOR, 8'ha5, 8'ha5, 4'b0001, "R6");
    apply(OAND, 8'hf0, 8'h0f, 4'b0000, "R5");
  endtask

  // R7 every accumulator value, both carry inputs
  task automatic t_incdec();
    for (int a = 0; a < 256; a++)
      for (int ci = 0; ci < 2; ci++) begin
        apply(OINC, a, 0, {3'b010, 1'(ci)}, "R7");
        apply(ODEC, a, 0, {3'b100, 1'(ci)}, "R7");
      end
  endtask

  // R9 carry control over all incoming flag patterns
  task automatic t_carry_ctl();
    for (int f = 0; f < 16; f++) begin
      apply(OSCF, 16'h1234, 16'h00aa, 4'(f), "R9");
      apply(OCCF, 16'hbeef, 16'h0055, 4'(f), "R9");
    end
  endtask

  // R10 pair add corners
  task automatic t_pair_add();
    int va[8] = '{16'h0fff, 16'h8000, 16'hffff, 16'h0800, 16'h7fff, 16'h0000, 16'h1234, 16'hf000};
    int vb[8] = '{16'h0001, 16'h8000, 16'h0001, 16'h0800, 16'h0001, 16'h0000, 16'h4321, 16'h1000};
    for (int i = 0; i < 8; i++) begin
      apply(OADDW, va[i], vb[i], 4'b1000, "R10");
      apply(OADDW, va[i], vb[i], 4'b0111, "R10");
    end
  endtask

  // R11 stack add corners: sign extension and low-byte carries
  task automatic t_stack_add();
    int va[8] = '{16'hfff8, 16'h0000, 16'h00ff, 16'h000f, 16'h1000, 16'hffff, 16'h0080, 16'h8000};
    int vb[8] = '{16'h0008, 16'h00ff, 16'h0001, 16'h0001, 16'h0080, 16'h0001, 16'h0080, 16'hff7f};
    for (int i = 0; i < 8; i++)
      apply(OADDSP, va[i], vb[i], 4'b1111, "R11");
  endtask

  // R12 pass-through keeps all flags
  task automatic t_nop();
    for (int f = 0; f < 16; f++)
      apply(ONOP, 16'ha5c3 ^ f, 16'hffff, 4'(f), "R12");
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_plain_arith();
    t_logic();
    t_incdec();
    t_carry_ctl();
    t_pair_add();
    t_stack_add();
    t_nop();
    t_adc_sweep();
    t_sbc_sweep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule